// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Capture Buffer

This block sits behind an E1 receive framer. The framer supplies the byte from timeslot 0 of each frame, a strobe that marks it, and the number of that frame within the 16-frame multiframe. In odd-numbered frames this byte carries five national-use spare bits, Sa4 to Sa8. The block gathers them into five shadow bytes as the multiframe goes by. When the frame 15 byte arrives, it moves all five shadow bytes into visible registers in a single step.

The visible registers then hold still for the whole of the next multiframe, which is about 2 ms of line time. A processor reads them through a small read port, and the same values also appear in parallel on an output bus. When the registers update, a single-cycle interrupt marks the event. A valid flag shows whether the contents can be trusted. The flag drops whenever the receiver is in T1 mode or has lost frame alignment. It comes back only after a full multiframe has been captured from a clean multiframe start.

Top module: `e1_sa_top`

## Requirements
- R1: Taking bit 7 of `rx_byte_i` as the first bit transmitted, Sa4 is taken from bit 4, Sa5 from bit 3, Sa6 from bit 2, Sa7 from bit 1 and Sa8 from bit 0. Bits 7 to 5 are never stored.
- R2: Only bytes strobed in odd frames (`frame_idx_i` = 1, 3, ..., 15) are captured, and frame 2k+1 lands in bit k of each Sa byte. Bytes in even frames, and any byte present while `ts0_stb_i` is low, have no effect.
- R3: In the cycle after the strobe of frame 15, `mf_irq_o` is high for exactly one cycle. All five visible bytes take the shadow contents at the clock edge that ends that cycle.
- R4: Outside that update, the visible bytes on `sa_bytes_o` do not change. Sa4 is at bits 7:0, Sa5 at 15:8, and so on up to Sa8 at 39:32.
- R5: While `t1_mode_i` or `fas_lost_i` is high, no interrupt is raised and the visible bytes keep their values.
- R6: `sa_valid_o` is low after reset. It falls one cycle after `t1_mode_i` or `fas_lost_i` is seen high. It rises only at an update that follows a `mf_start_i` pulse, with no T1 mode or alignment loss in between.
- R7: Read address 0 to 4 returns the visible Sa4 to Sa8 bytes in that order. Addresses 5 to 7 read as 0.
- R8: Reset clears the shadow and visible bytes to 0 and holds `mf_irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_byte_i | input | 8 | Received timeslot 0 byte |
| ts0_stb_i | input | 1 | Marks `rx_byte_i` as the timeslot 0 byte of a frame |
| frame_idx_i | input | 4 | Frame number within the multiframe, 0 to 15 |
| mf_start_i | input | 1 | Pulse at the start of a multiframe (frame 0) |
| t1_mode_i | input | 1 | 1 selects T1 operation |
| fas_lost_i | input | 1 | Frame alignment lost |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Read data |
| sa_bytes_o | output | 40 | All five visible Sa bytes |
| mf_irq_o | output | 1 | Multiframe update pulse |
| sa_valid_o | output | 1 | Visible contents are trustworthy |

## Verification
The hardest state to reach from the ports is the difference between an update that is allowed and an update that may be trusted. This happens when alignment returns partway through a multiframe. The block then commits and interrupts, but it must keep the valid flag low. The stimulus drops alignment for a whole multiframe, restores it, and sends a multiframe that has no start pulse. It checks that the interrupt and the new bytes appear while the flag stays low. The flag is expected to rise only after the next multiframe that has a start pulse. Every odd frame carries distinct bits per Sa field, and even frames and unstrobed bytes carry inverted junk, so a wrong bit position or a wrong frame gate shows up at once in the compared bytes.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int NUM_SA       = 5;
  localparam int FRAMES_MF    = 16;
  localparam int SA_FIRST_POS = 4;  // transmission position (1-based) of Sa4
  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = 3;
endpackage

// File: rtl/e1_sa_shadow.sv
module e1_sa_shadow #(
  parameter int NUM_SA    = e1_sa_pkg::NUM_SA,
  parameter int FRAMES_MF = e1_sa_pkg::FRAMES_MF,
  parameter int BYTE_W    = e1_sa_pkg::BYTE_W,
  localparam int BITS     = FRAMES_MF / 2,
  localparam int FN_W     = $clog2(FRAMES_MF)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cap_en_i,
  input  logic [FN_W-1:0]        frame_i,
  input  logic [BYTE_W-1:0]      byte_i,
  output logic [NUM_SA*BITS-1:0] shadow_o
);
  logic [FN_W-2:0] slot;
  logic            odd_hit;

  assign slot    = frame_i[FN_W-1:1];
  assign odd_hit = cap_en_i & frame_i[0];

  for (genvar s = 0; s < NUM_SA; s++) begin : g_sa
    localparam int SRC = BYTE_W - e1_sa_pkg::SA_FIRST_POS - s;
    logic [BITS-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      sh_q <= '0;
      else if (odd_hit) sh_q[slot] <= byte_i[SRC];
    end
    assign shadow_o[s*BITS +: BITS] = sh_q;
  end
endmodule

// File: rtl/e1_sa_ctrl.sv
module e1_sa_ctrl #(
  parameter int FRAMES_MF = e1_sa_pkg::FRAMES_MF,
  localparam int FN_W     = $clog2(FRAMES_MF)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stb_i,
  input  logic [FN_W-1:0] frame_i,
  input  logic            mf_start_i,
  input  logic            t1_i,
  input  logic            lost_i,
  output logic            commit_o,
  output logic            valid_o
);
  localparam logic [FN_W-1:0] LAST_FRAME = FN_W'(FRAMES_MF - 1);

  logic bad, commit_q, clean_q, valid_q;

  assign bad      = t1_i | lost_i;
  assign commit_o = commit_q & ~bad;
  assign valid_o  = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_q <= 1'b0;
      clean_q  <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      commit_q <= stb_i & (frame_i == LAST_FRAME) & ~bad;
      // clean: a multiframe start seen with no disturbance since
      if (bad)             clean_q <= 1'b0;
      else if (mf_start_i) clean_q <= 1'b1;
      if (bad)                      valid_q <= 1'b0;
      else if (commit_o && clean_q) valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/e1_sa_bank.sv
module e1_sa_bank #(
  parameter int NUM_SA = e1_sa_pkg::NUM_SA,
  parameter int BITS   = e1_sa_pkg::BYTE_W,
  parameter int ADDR_W = e1_sa_pkg::ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   commit_i,
  input  logic [NUM_SA*BITS-1:0] shadow_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [NUM_SA*BITS-1:0] vis_o,
  output logic [BITS-1:0]        rd_data_o
);
  logic [NUM_SA*BITS-1:0] vis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vis_q <= '0;
    else if (commit_i) vis_q <= shadow_i;
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_SA; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = vis_q[i*BITS +: BITS];
  end

  assign vis_o = vis_q;
endmodule

// File: rtl/e1_sa_top.sv
module e1_sa_top #(
  parameter int NUM_SA    = e1_sa_pkg::NUM_SA,
  parameter int FRAMES_MF = e1_sa_pkg::FRAMES_MF,
  parameter int BYTE_W    = e1_sa_pkg::BYTE_W,
  parameter int ADDR_W    = e1_sa_pkg::ADDR_W,
  localparam int BITS     = FRAMES_MF / 2,
  localparam int FN_W     = $clog2(FRAMES_MF)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [BYTE_W-1:0]      rx_byte_i,
  input  logic                   ts0_stb_i,
  input  logic [FN_W-1:0]        frame_idx_i,
  input  logic                   mf_start_i,
  input  logic                   t1_mode_i,
  input  logic                   fas_lost_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output logic [BITS-1:0]        rd_data_o,
  output logic [NUM_SA*BITS-1:0] sa_bytes_o,
  output logic                   mf_irq_o,
  output logic                   sa_valid_o
);
  logic [NUM_SA*BITS-1:0] shadow;
  logic                   commit;

  e1_sa_shadow #(.NUM_SA(NUM_SA), .FRAMES_MF(FRAMES_MF), .BYTE_W(BYTE_W)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (ts0_stb_i & ~t1_mode_i),
    .frame_i  (frame_idx_i),
    .byte_i   (rx_byte_i),
    .shadow_o (shadow)
  );

  e1_sa_ctrl #(.FRAMES_MF(FRAMES_MF)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (ts0_stb_i),
    .frame_i    (frame_idx_i),
    .mf_start_i (mf_start_i),
    .t1_i       (t1_mode_i),
    .lost_i     (fas_lost_i),
    .commit_o   (commit),
    .valid_o    (sa_valid_o)
  );

  e1_sa_bank #(.NUM_SA(NUM_SA), .BITS(BITS), .ADDR_W(ADDR_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .shadow_i  (shadow),
    .rd_addr_i (rd_addr_i),
    .vis_o     (sa_bytes_o),
    .rd_data_o (rd_data_o)
  );

  assign mf_irq_o = commit;
endmodule

// File: rtl/e1_sa_chk.sv
module e1_sa_chk #(
  parameter int NUM_SA = 5,
  parameter int BITS   = 8,
  parameter int ADDR_W = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   t1_mode_i,
  input logic                   fas_lost_i,
  input logic [ADDR_W-1:0]      rd_addr_i,
  input logic [BITS-1:0]        rd_data_o,
  input logic [NUM_SA*BITS-1:0] sa_bytes_o,
  input logic                   mf_irq_o,
  input logic                   sa_valid_o
);
  p_irq_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_irq_o |=> !mf_irq_o);

  p_bytes_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mf_irq_o |=> $stable(sa_bytes_o));

  p_irq_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_mode_i || fas_lost_i) |-> !mf_irq_o);

  p_valid_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_mode_i || fas_lost_i) |=> !sa_valid_o);

  p_valid_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sa_valid_o) |-> $past(mf_irq_o));

  p_rd_rsv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_addr_i) >= NUM_SA) |-> (rd_data_o == '0));

  p_rd_map_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_addr_i) < NUM_SA) |-> (rd_data_o == sa_bytes_o[int'(rd_addr_i)*BITS +: BITS]));
endmodule

bind e1_sa_top e1_sa_chk #(.NUM_SA(NUM_SA), .BITS(BITS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .t1_mode_i  (t1_mode_i),
  .fas_lost_i (fas_lost_i),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o),
  .sa_bytes_o (sa_bytes_o),
  .mf_irq_o   (mf_irq_o),
  .sa_valid_o (sa_valid_o)
);

// File: tb/sim_e1_sa_top.sv
`timescale 1ns/1ps
module sim_e1_sa_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        stb = 1'b0;
  logic [3:0]  frame = '0;
  logic        mf_start = 1'b0;
  logic        t1 = 1'b0;
  logic        lost = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [39:0] sa_bytes;
  logic        irq;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [39:0] exp_q[$];
  logic [39:0] pend;
  bit          cmp_next = 0;
  logic [39:0] last_bytes = '0;

  always #2 clk = ~clk;

  e1_sa_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_byte_i(rx_byte), .ts0_stb_i(stb),
    .frame_idx_i(frame), .mf_start_i(mf_start), .t1_mode_i(t1), .fas_lost_i(lost),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .sa_bytes_o(sa_bytes),
    .mf_irq_o(irq), .sa_valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R1: Sa(4+s) sits at byte bit 4-s; R2: frame 2k+1 -> bit k
  function automatic logic [7:0] build(input logic [39:0] pat, input int f);
    logic [7:0] b;
    b = 8'(f) << 5;
    for (int s = 0; s < 5; s++) b[4-s] = pat[s*8 + f/2];
    return b;
  endfunction

  task automatic send_mf(input logic [39:0] pat, input bit boundary, input bit expect_commit,
                         input bit mid_chk, input logic [39:0] prev);
    if (expect_commit) exp_q.push_back(pat);
    for (int f = 0; f < 16; f++) begin
      @(negedge clk);
      if (mid_chk && f == 8) check(sa_bytes == prev, "R4 mid-multiframe hold", 64'(sa_bytes), 64'(prev));
      mf_start = boundary && (f == 0);
      stb      = 1'b1;
      frame    = 4'(f);
      rx_byte  = (f % 2 == 1) ? build(pat, f) : ~build(pat, f + 1);  // even frames: junk
      @(negedge clk);
      stb      = 1'b0;
      mf_start = 1'b0;
      rx_byte  = ~build(pat, f | 1);  // junk with strobe low
      repeat (2) @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // Monitor: scoreboard for updates, hold check otherwise
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cmp_next) begin
        check(sa_bytes == pend, "R3 committed bytes", 64'(sa_bytes), 64'(pend));
        check(!irq, "R3 interrupt single cycle", 64'(irq), 64'(0));
        cmp_next = 0;
      end else if (sa_bytes != last_bytes) begin
        check(0, "R4 bytes changed without update", 64'(sa_bytes), 64'(last_bytes));
      end
      if (irq && !cmp_next) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected interrupt", 64'(1), 64'(0));
        else begin
          pend = exp_q.pop_front();
          check(sa_bytes == last_bytes, "R3 bytes old during interrupt", 64'(sa_bytes), 64'(last_bytes));
          cmp_next = 1;
        end
      end
      last_bytes = sa_bytes;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [39:0] PA = {8'hC3, 8'h0F, 8'hF0, 8'h81, 8'h5A};
  localparam logic [39:0] PB = {8'h3C, 8'hE7, 8'h18, 8'hAA, 8'h55};
  localparam logic [39:0] PC = {8'h96, 8'h01, 8'h80, 8'h7E, 8'h33};
  localparam logic [39:0] PD = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
  localparam logic [39:0] PE = {8'h11, 8'h22, 8'h44, 8'h88, 8'h99};
  localparam logic [39:0] PF = {8'h6D, 8'hB2, 8'h4C, 8'hD3, 8'h27};
  localparam logic [39:0] PG = {8'h00, 8'hFE, 8'h0E, 8'hE0, 8'h71};

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(sa_bytes == '0, "R8 bytes after reset", 64'(sa_bytes), 64'(0));
    check(!irq, "R8 no interrupt in reset", 64'(irq), 64'(0));
    check(!valid, "R6 valid low in reset", 64'(valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 8'h00, "R8 read after reset", 64'(rd_data), 64'(0));

    send_mf(PA, 1, 1, 0, '0);
    check(valid, "R6 valid after clean multiframe", 64'(valid), 64'(1));
    for (int a = 0; a < 8; a++) begin
      logic [7:0] e;
      rd_addr = 3'(a);
      e = (a < 5) ? PA[a*8 +: 8] : 8'h00;
      #1;
      check(rd_data == e, (a < 5) ? "R7 read Sa byte" : "R7 reserved read zero", 64'(rd_data), 64'(e));
    end
    rd_addr = '0;

    // R1/R2: distinct pattern with junk in even frames and unstrobed bytes
    send_mf(PB, 1, 1, 0, '0);
    check(sa_bytes == PB, "R2 odd frames only", 64'(sa_bytes), 64'(PB));

    // R4: hold through the next multiframe
    send_mf(PC, 1, 1, 1, PB);

    // R5/R6: alignment loss
    @(negedge clk); lost = 1'b1;
    repeat (2) @(negedge clk);
    check(!valid, "R6 valid drops on alignment loss", 64'(valid), 64'(0));
    send_mf(PD, 1, 0, 0, '0);
    check(sa_bytes == PC, "R5 bytes held while lost", 64'(sa_bytes), 64'(PC));
    lost = 1'b0;

    // R6: recovery without a multiframe start commits but stays invalid
    send_mf(PE, 0, 1, 0, '0);
    check(sa_bytes == PE, "R3 update after recovery", 64'(sa_bytes), 64'(PE));
    check(!valid, "R6 no valid without multiframe start", 64'(valid), 64'(0));
    send_mf(PF, 1, 1, 0, '0);
    check(valid, "R6 valid after clean start", 64'(valid), 64'(1));

    // R5/R6: T1 mode
    @(negedge clk); t1 = 1'b1;
    send_mf(PG, 1, 0, 0, '0);
    check(sa_bytes == PF, "R5 bytes held in T1", 64'(sa_bytes), 64'(PF));
    check(!valid, "R6 valid low in T1", 64'(valid), 64'(0));
    t1 = 1'b0;

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0 && !cmp_next, "R3 all expected updates seen", 64'(exp_q.size()), 64'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule